// File: doc/BRIEF.md
# Profile-Switched Direct Digital Synthesizer

This block is a direct digital synthesis core. A 32-bit phase accumulator adds the active tuning word on every clock. A 16-bit phase offset is added to the upper part of the running phase, and the top ten bits of that sum index a quarter-wave sine table. The table yields a registered 10-bit signed sample. The output frequency is the tuning word times the clock rate divided by 2^32, so one step of the tuning word moves the output by the clock rate over 2^32.

Four profiles each hold one tuning word and one phase offset. A two-bit select input picks the profile that drives the accumulator. Once the profiles are loaded, changing the select is enough to hop between four frequencies, and no register write is needed for the hop. The accumulator is never cleared on a hop, so the phase stays continuous.

Software writes bytes through an address, data and write-enable port into a staging copy of all profiles. The staged words reach the live profiles only on a rising edge of the update strobe, or when the select input takes a new value.

Top module: `dds_profile_core`

## Requirements
- R1: On every clock edge out of reset the accumulator adds the tuning word of the registered profile, modulo 2^32. With the tuning word 0x20000000 active and no hop, the sample sequence repeats with a period of exactly 8 cycles.
- R2: The table phase p is bits 15:6 of the 16-bit sum of accumulator bits 31:16 and the active offset. Bit 9 of p negates the sample and bit 8 mirrors the quarter index (k = 255 - p[7:0], else k = p[7:0]). The magnitude is floor(511*16*t / (5*1024^2 - 4*t)) with h = 2k+1 and t = h*(1024-h). The sample is never -512.
- R3: The sample output is a register. The value after edge e is computed from the accumulator and the active offset as they were just before edge e.
- R4: While rst_n is low, sample, accumulator, registered select, registered strobe and all staged and live words are zero.
- R5: A write with wr_en high updates only the staged copy. Address bits 4:3 pick the profile. Bits 2:0 equal to 0..3 write tuning-word byte 0..3, with byte 0 being bits 7:0. Bits 2:0 equal to 4 or 5 write offset bits 7:0 or 15:8.
- R6: All staged words are copied to the live profiles at an edge where update is high and was low at the previous edge, or where sel differs from its registered value. Holding update high commits only once. A write at the same edge as a commit is not included in that commit.
- R7: A hop never clears or reloads the accumulator; only its increment changes.
- R8: The sel input is registered once. The new profile's offset shapes the sample produced at the edge after sel is registered, and the new profile's tuning word is added at that same edge.
- R9: The phase offset affects only the table phase and never the accumulator. Removing an offset brings back exactly the unshifted samples.
- R10: Writes with address bits 2:0 equal to 6 or 7 change no staged or live word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write enable into the staged profiles |
| wr_addr | input | 5 | Write address: profile in bits 4:3, byte slot in bits 2:0 |
| wr_data | input | 8 | Write data byte |
| update | input | 1 | Commit strobe; acts on its rising edge |
| sel | input | 2 | Active profile select |
| sample | output | 10 | Signed sine amplitude sample |

## Verification
The assertions assume that update, sel and the write port are synchronous to clk and are held low or at zero through reset. Only under that assumption do the registered strobe and select start from a known edge-detect state. The bench drives every input only at falling clock edges and keeps sel and update at zero while reset is asserted, so no commit or hop is seen at the first active edge. The bench's reference model samples those inputs at the rising edge in the same way the assertions do.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int DDS_ACC_W  = 32;
    localparam int DDS_OFS_W  = 16;
    localparam int DDS_PH_W   = 10;
    localparam int DDS_AMP_W  = 10;
    localparam int DDS_NPROF  = 4;
    localparam int DDS_DATA_W = 8;
endpackage

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int PH_W  = dds_pkg::DDS_PH_W,
    parameter int AMP_W = dds_pkg::DDS_AMP_W
) (
    input  logic [PH_W-1:0]         ph,
    output logic signed [AMP_W-1:0] amp
);
    localparam int QD   = 2 ** (PH_W - 2);
    localparam int QW   = PH_W - 2;
    localparam int MAGW = AMP_W - 1;

    // Rational sine approximation evaluated at the centre of each quarter-wave slot
    function automatic logic [MAGW-1:0] quarter_amp(input int k);
        longint n, h, t, amax, val;
        n    = longint'(1) <<< PH_W;
        h    = 2 * longint'(k) + 1;
        t    = h * (n - h);
        amax = (longint'(1) <<< MAGW) - 1;
        val  = (amax * 16 * t) / (5 * n * n - 4 * t);
        return MAGW'(val);
    endfunction

    logic [MAGW-1:0] rom [QD];

    for (genvar k = 0; k < QD; k++) begin : g_rom
        localparam logic [MAGW-1:0] VAL = quarter_amp(k);
        assign rom[k] = VAL;
    end

    logic [QW-1:0]    idx;
    logic [AMP_W-1:0] mag;

    always_comb begin
        idx = ph[PH_W-2] ? ~ph[QW-1:0] : ph[QW-1:0];
        mag = {1'b0, rom[idx]};
        amp = ph[PH_W-1] ? -mag : mag;
    end
endmodule

// File: rtl/dds_profile_bank.sv
module dds_profile_bank #(
    parameter int NPROF  = dds_pkg::DDS_NPROF,
    parameter int ACC_W  = dds_pkg::DDS_ACC_W,
    parameter int OFS_W  = dds_pkg::DDS_OFS_W,
    parameter int DATA_W = dds_pkg::DDS_DATA_W,
    parameter int ADDR_W = $clog2(NPROF) + $clog2(ACC_W / DATA_W) + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              commit,
    output logic [NPROF-1:0][ACC_W-1:0]       act_f,
    output logic [NPROF-1:0][OFS_W-1:0]       act_o
);
    localparam int FB     = ACC_W / DATA_W;
    localparam int OB     = OFS_W / DATA_W;
    localparam int SLOT_B = $clog2(FB) + 1;

    typedef struct packed {
        logic [NPROF-1:0][ACC_W-1:0] stg_f;
        logic [NPROF-1:0][OFS_W-1:0] stg_o;
        logic [NPROF-1:0][ACC_W-1:0] act_f;
        logic [NPROF-1:0][OFS_W-1:0] act_o;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        int prof;
        int slot;
        b_d  = b_q;
        prof = int'(wr_addr[ADDR_W-1:SLOT_B]);
        slot = int'(wr_addr[SLOT_B-1:0]);
        if (commit) begin
            b_d.act_f = b_q.stg_f;
            b_d.act_o = b_q.stg_o;
        end
        if (wr_en && prof < NPROF) begin
            if (slot < FB) begin
                b_d.stg_f[prof][slot*DATA_W +: DATA_W] = wr_data;
            end else if (slot < FB + OB) begin
                b_d.stg_o[prof][(slot-FB)*DATA_W +: DATA_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign act_f = b_q.act_f;
    assign act_o = b_q.act_o;
endmodule

// File: rtl/dds_profile_core.sv
module dds_profile_core #(
    parameter int ACC_W  = dds_pkg::DDS_ACC_W,
    parameter int OFS_W  = dds_pkg::DDS_OFS_W,
    parameter int PH_W   = dds_pkg::DDS_PH_W,
    parameter int AMP_W  = dds_pkg::DDS_AMP_W,
    parameter int NPROF  = dds_pkg::DDS_NPROF,
    parameter int DATA_W = dds_pkg::DDS_DATA_W,
    parameter int SEL_W  = $clog2(NPROF),
    parameter int ADDR_W = $clog2(NPROF) + $clog2(ACC_W / DATA_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     update,
    input  logic [SEL_W-1:0]         sel,
    output logic signed [AMP_W-1:0]  sample
);
    typedef struct packed {
        logic [SEL_W-1:0]        sel_q;
        logic                    upd_q;
        logic [ACC_W-1:0]        acc;
        logic signed [AMP_W-1:0] sample;
    } core_t;

    core_t r_d, r_q;

    logic                        commit;
    logic [NPROF-1:0][ACC_W-1:0] act_f;
    logic [NPROF-1:0][OFS_W-1:0] act_o;
    logic [ACC_W-1:0]            cur_step;
    logic [OFS_W-1:0]            cur_pow;
    logic [PH_W-1:0]             rom_ph;
    logic signed [AMP_W-1:0]     rom_amp;

    dds_profile_bank #(
        .NPROF(NPROF), .ACC_W(ACC_W), .OFS_W(OFS_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .commit (commit),
        .act_f  (act_f),
        .act_o  (act_o)
    );

    dds_sine_rom #(.PH_W(PH_W), .AMP_W(AMP_W)) u_rom (
        .ph (rom_ph),
        .amp(rom_amp)
    );

    always_comb begin
        commit   = (update & ~r_q.upd_q) | (sel != r_q.sel_q);
        cur_step = act_f[r_q.sel_q];
        cur_pow  = act_o[r_q.sel_q];
        rom_ph   = PH_W'((r_q.acc[ACC_W-1 -: OFS_W] + cur_pow) >> (OFS_W - PH_W));

        r_d        = r_q;
        r_d.acc    = r_q.acc + cur_step;
        r_d.sample = rom_amp;
        r_d.sel_q  = sel;
        r_d.upd_q  = update;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sample = r_q.sample;
endmodule

// File: rtl/dds_profile_checker.sv
module dds_profile_checker #(
    parameter int ACC_W = dds_pkg::DDS_ACC_W,
    parameter int OFS_W = dds_pkg::DDS_OFS_W,
    parameter int AMP_W = dds_pkg::DDS_AMP_W,
    parameter int NPROF = dds_pkg::DDS_NPROF,
    parameter int SEL_W = $clog2(NPROF)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        update,
    input logic [SEL_W-1:0]            sel,
    input logic [SEL_W-1:0]            sel_q,
    input logic                        upd_q,
    input logic [ACC_W-1:0]            acc,
    input logic [NPROF-1:0][ACC_W-1:0] act_f,
    input logic [NPROF-1:0][OFS_W-1:0] act_o,
    input logic [ACC_W-1:0]            cur_step,
    input logic [OFS_W-1:0]            cur_pow,
    input logic                        commit,
    input logic signed [AMP_W-1:0]     sample
);
    logic [2:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age <= '0;
        else if (age != 7) age <= age + 3'd1;
    end

    // R5 / R6: live profiles move only at a commit event
    assert_stage_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(update && !upd_q) && sel == sel_q) |=> ($stable(act_f) && $stable(act_o)))
        else $error("live profile changed without a commit");

    // R1 / R7: the accumulator increment stays fixed while no commit occurs
    assert_step_constant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3 && !$past(commit, 2)) |->
        ((acc - $past(acc)) == ($past(acc) - $past(acc, 2))))
        else $error("accumulator increment changed without a commit");

    // R3: with a zero step and a steady offset the registered sample holds
    assert_hold_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 4 && $past(cur_step, 2) == '0 && $past(cur_pow) == $past(cur_pow, 2))
        |-> $stable(sample))
        else $error("sample moved with frozen phase");

    // R2: the symmetric table never reaches the most negative code
    assert_sample_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sample != {1'b1, {(AMP_W-1){1'b0}}})
        else $error("sample reached most negative code");
endmodule

bind dds_profile_core dds_profile_checker #(
    .ACC_W(ACC_W), .OFS_W(OFS_W), .AMP_W(AMP_W), .NPROF(NPROF), .SEL_W(SEL_W)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .update  (update),
    .sel     (sel),
    .sel_q   (r_q.sel_q),
    .upd_q   (r_q.upd_q),
    .acc     (r_q.acc),
    .act_f   (act_f),
    .act_o   (act_o),
    .cur_step(cur_step),
    .cur_pow (cur_pow),
    .commit  (commit),
    .sample  (sample)
);

// File: tb/dds_profile_core_test.sv
module dds_profile_core_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              update = 1'b0;
    logic [1:0]        sel = '0;
    logic signed [9:0] sample;

    always #5 clk = ~clk;

    dds_profile_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .update(update), .sel(sel), .sample(sample)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference state derived from the requirements
    logic [31:0]       m_sf [4];
    logic [31:0]       m_af [4];
    logic [15:0]       m_so [4];
    logic [15:0]       m_ao [4];
    logic [1:0]        m_sel = '0;
    logic              m_upd = 1'b0;
    logic [31:0]       m_acc = '0;
    logic signed [9:0] m_samp = '0;

    function automatic logic signed [9:0] ref_wave(input logic [9:0] p);
        longint k, h, t, a;
        logic signed [9:0] r;
        k = longint'(p[7:0]);
        if (p[8]) k = 255 - k;
        h = 2 * k + 1;
        t = h * (1024 - h);
        a = (511 * 16 * t) / (5 * 1024 * 1024 - 4 * t);
        r = 10'(a);
        return p[9] ? -r : r;
    endfunction

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        logic [15:0] ps;
        logic signed [9:0] nxt;
        bit cm;
        int s;
        @(posedge clk);
        ps  = m_acc[31:16] + m_ao[m_sel];
        nxt = ref_wave(ps[15:6]);
        cm  = (update && !m_upd) || (sel != m_sel);
        m_acc = m_acc + m_af[m_sel];
        if (cm) begin
            for (int i = 0; i < 4; i++) begin
                m_af[i] = m_sf[i];
                m_ao[i] = m_so[i];
            end
        end
        if (wr_en) begin
            s = int'(wr_addr[2:0]);
            if (s < 4)       m_sf[wr_addr[4:3]][s*8 +: 8] = wr_data;
            else if (s < 6)  m_so[wr_addr[4:3]][(s-4)*8 +: 8] = wr_data;
        end
        m_sel  = sel;
        m_upd  = update;
        m_samp = nxt;
        @(negedge clk);
        check_val(tag, int'(sample), int'(m_samp));
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
        wr_en = 1'b0;
    endtask

    task automatic load_ftw(input int p, input logic [31:0] w, input string tag);
        for (int b = 0; b < 4; b++) wr(5'(p * 8 + b), w[b*8 +: 8], tag);
    endtask

    task automatic load_ofs(input int p, input logic [15:0] w, input string tag);
        for (int b = 0; b < 2; b++) wr(5'(p * 8 + 4 + b), w[b*8 +: 8], tag);
    endtask

    task automatic pulse_update(input string tag);
        update = 1'b1;
        tick(tag);
        update = 1'b0;
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int mx, mn;
        logic signed [9:0] rec [16];
        for (int i = 0; i < 4; i++) begin
            m_sf[i] = '0; m_af[i] = '0; m_so[i] = '0; m_ao[i] = '0;
        end

        // R4: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_val("R4 reset sample", int'(sample), 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) tick("R4 after reset");

        // R2: exhaustive table sweep, one address per cycle
        load_ftw(0, 32'h0040_0000, "R5 load");
        pulse_update("R6 commit");
        mx = -1000; mn = 1000;
        for (int i = 0; i < 1030; i++) begin
            tick("R2 sweep");
            if (int'(sample) > mx) mx = int'(sample);
            if (int'(sample) < mn) mn = int'(sample);
        end
        check_val("R2 symmetric peak", mx, -mn);
        check_val("R2 peak bound", int'(mx <= 511 && mx >= 500), 1);

        // R5: staged tuning word stays inactive
        load_ftw(0, 32'h2000_0000, "R5 staged");
        for (int i = 0; i < 20; i++) tick("R5 not live");

        // R6: held strobe commits once; later writes wait
        update = 1'b1;
        tick("R6 rise");
        load_ofs(0, 16'h4000, "R6 held");
        for (int i = 0; i < 10; i++) tick("R6 held high");
        update = 1'b0;
        tick("R6 fall");

        // R1: period of eight with tuning word 0x20000000
        for (int i = 0; i < 16; i++) begin
            tick("R1 run");
            rec[i] = sample;
        end
        for (int i = 0; i < 8; i++)
            check_val("R1 period eight", int'(rec[i+8]), int'(rec[i]));

        // Profiles for hopping
        load_ftw(1, 32'h1999_9999, "R5 p1");
        load_ftw(2, 32'h0400_0000, "R5 p2");
        load_ofs(2, 16'h8000, "R5 p2 ofs");
        load_ftw(3, 32'h0400_0000, "R5 p3");
        pulse_update("R6 commit all");

        // R7 / R8 / R9: hop sequence
        foreach (rec[j]) rec[j] = '0;
        begin
            logic [1:0] seq [7] = '{2'd1, 2'd2, 2'd3, 2'd2, 2'd0, 2'd3, 2'd1};
            foreach (seq[j]) begin
                sel = seq[j];
                tick("R8 hop edge");
                tick("R8 hop second");
                for (int i = 0; i < 12; i++) tick(sel == 2 ? "R9 offset" : "R7 continuous");
            end
        end

        // R9: offset removed restores unshifted samples
        load_ofs(0, 16'h0000, "R9 clear");
        sel = 2'd0;
        tick("R6 sel commit");
        for (int i = 0; i < 12; i++) tick("R9 unshifted");

        // R6: a select change alone commits staged words
        load_ftw(1, 32'h0800_0000, "R6 stage p1");
        sel = 2'd1;
        for (int i = 0; i < 16; i++) tick("R6 sel commit run");

        // R10: unused slots ignored
        for (int p = 0; p < 4; p++) begin
            wr(5'(p * 8 + 6), 8'hFF, "R10 slot6");
            wr(5'(p * 8 + 7), 8'hFF, "R10 slot7");
        end
        update = 1'b1;
        tick("R10 commit");
        update = 1'b0;
        for (int p = 0; p < 4; p++) begin
            sel = 2'(p);
            for (int i = 0; i < 10; i++) tick("R10 unchanged");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule